// File: doc/BRIEF.md
# Interruptible Memory-Mapped Integer Divider

This block computes the quotient and the remainder of two integers for a processor that reaches it over a simple register bus. A calculation starts when software writes an operand register. Each operand register has two addresses. The address used for the write picks signed or unsigned mode. The calculation takes a fixed number of clock cycles, which is `DATA_W/STEP_BITS`, or 8 at the default parameters. Software reads the results after that fixed wait, or polls a ready flag.

An interrupt handler may need the divider while another context is part-way through a division. To support this, the unit exposes two status flags:
- A dirty flag records that the unit has been touched since its quotient was last read.
- A ready flag records that the result registers hold valid values.

Every register that holds state can be read back. The result registers can also be written. A handler saves the operands and the results. It runs its own division. It then writes the operands, the remainder and the quotient back in that order. Writing a result register stops any division still running, so that division cannot overwrite the restored values later.

Top module: `intdiv_mmio`

## Requirements
- R1: Register addresses are as follows:
  - 0 is the unsigned dividend and 2 is the signed dividend.
  - 1 is the unsigned divisor and 3 is the signed divisor.
  - 4 is the quotient and 5 is the remainder.
  - 6 is the status register.
  
  A write to any of addresses 0 to 3 starts a calculation. Addresses 2 and 3 start it in signed mode, and addresses 0 and 1 start it in unsigned mode.
- R2: After the clock edge that takes the starting write, the ready bit reads 1 on the `DATA_W/STEP_BITS`-th following edge and not before. The results are valid from that edge on.
- R3: The ready bit is status bit 0. It reads 0 while a calculation runs and 1 when the result registers are valid. After reset it reads 1.
- R4: The dirty bit is status bit 1. After reset it reads 0. A write to any operand or result address sets it.
- R5: A bus read of the quotient address clears the dirty bit. A read of the remainder address leaves the dirty bit unchanged.
- R6: Both the dividend and the divisor read back, at either of their two addresses, as the last value written.
- R7: A write to the remainder address does three things. It loads the written value. It stops any calculation in progress, so the result registers do not change later. It sets both ready and dirty.
- R8: A write to the quotient address does three things. It loads the written value. It stops any calculation in progress. It sets both ready and dirty.
- R9: Signed division truncates toward zero, and the remainder takes the sign of the dividend. The most negative value divided by -1 gives the most negative value as the quotient and 0 as the remainder.
- R10: Division by zero gives a remainder equal to the dividend. The quotient is as follows:
  - In unsigned mode it is all ones.
  - In signed mode it is -1 for a non-negative dividend and +1 for a negative dividend.
  
  Ready is still set after the normal latency.
- R11: The status register reads zero in every bit above bit 1, so the mode of the last calculation cannot be read back. Writes to the status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_rd | input | 1 | Read strobe; only its side effect on the dirty bit is clocked |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |

## Verification
The bench sweeps every dividend of an 8-bit instance against a set of divisors in both modes. The divisor set includes zero, one and the values next to the sign boundary. A faulty sign correction shows up there as remainders with the wrong sign or quotients that are off by one. On the 32-bit instance the bench counts cycles to the ready edge, so an extra or a missing pipeline stage is caught.

The bench also writes the remainder in the middle of a calculation and then waits well past the normal latency. If the abort is missing, the stale quotient from the aborted calculation replaces the restored state. Further checks cover the dirty bit: a remainder read must leave it set, a quotient read must clear it, and a dirty bit that clears on the wrong read fails those checks.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_UDVD = 3'd0,
      A_UDSR = 3'd1,
      A_SDVD = 3'd2,
      A_SDSR = 3'd3,
      A_QUO  = 3'd4,
      A_REM  = 3'd5,
      A_STAT = 3'd6
   } reg_addr_e;

   localparam int STAT_READY = 0;
   localparam int STAT_DIRTY = 1;
endpackage

// File: rtl/intdiv_step.sv
// K restoring-division iterations unrolled into one combinational stage.
module intdiv_step #(
   parameter int W = 32,
   parameter int K = 4
) (
   input  logic [W-1:0] rem_i,
   input  logic [W-1:0] dvd_i,
   input  logic [W-1:0] quo_i,
   input  logic [W-1:0] dsr_i,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] dvd_o,
   output logic [W-1:0] quo_o
);
   logic [W-1:0] rem_c [K+1];
   logic [W-1:0] dvd_c [K+1];
   logic [W-1:0] quo_c [K+1];

   assign rem_c[0] = rem_i;
   assign dvd_c[0] = dvd_i;
   assign quo_c[0] = quo_i;

   for (genvar i = 0; i < K; i++) begin : g_bit
      logic [W:0] shifted;
      logic [W:0] diff;
      assign shifted      = {rem_c[i], dvd_c[i][W-1]};
      assign diff         = shifted - {1'b0, dsr_i};
      assign rem_c[i+1]   = diff[W] ? shifted[W-1:0] : diff[W-1:0];
      assign dvd_c[i+1]   = {dvd_c[i][W-2:0], 1'b0};
      assign quo_c[i+1]   = {quo_c[i][W-2:0], ~diff[W]};
   end

   assign rem_o = rem_c[K];
   assign dvd_o = dvd_c[K];
   assign quo_o = quo_c[K];
endmodule

// File: rtl/intdiv_core.sv
// Sequencer: magnitudes in, STEPS iterations, sign correction out.
module intdiv_core #(
   parameter int W = 32,
   parameter int K = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         signed_i,
   input  logic [W-1:0] dvd_i,
   input  logic [W-1:0] dsr_i,
   input  logic         abort_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);
   localparam int STEPS = W / K;
   localparam int CW    = $clog2(STEPS + 1);

   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  rem_q, dvd_q, quo_q, dsr_q;
   logic          negq_q, negr_q;
   logic [W-1:0]  rem_n, dvd_n, quo_n;

   logic          dvd_neg, dsr_neg;
   logic [W-1:0]  dvd_mag, dsr_mag;

   assign dvd_neg = signed_i & dvd_i[W-1];
   assign dsr_neg = signed_i & dsr_i[W-1];
   assign dvd_mag = dvd_neg ? (~dvd_i + 1'b1) : dvd_i;
   assign dsr_mag = dsr_neg ? (~dsr_i + 1'b1) : dsr_i;

   intdiv_step #(.W(W), .K(K)) u_step (
      .rem_i(rem_q), .dvd_i(dvd_q), .quo_i(quo_q), .dsr_i(dsr_q),
      .rem_o(rem_n), .dvd_o(dvd_n), .quo_o(quo_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         rem_q  <= '0;
         dvd_q  <= '0;
         quo_q  <= '0;
         dsr_q  <= '0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(STEPS);
         rem_q  <= '0;
         quo_q  <= '0;
         dvd_q  <= dvd_mag;
         dsr_q  <= dsr_mag;
         negq_q <= dvd_neg ^ dsr_neg;
         negr_q <= dvd_neg;
      end else if (abort_i) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         rem_q <= rem_n;
         dvd_q <= dvd_n;
         quo_q <= quo_n;
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CW'(1)) busy_q <= 1'b0;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == CW'(1)) && !start_i && !abort_i;
   assign quo_o  = negq_q ? (~quo_n + 1'b1) : quo_n;
   assign rem_o  = negr_q ? (~rem_n + 1'b1) : rem_n;

   // R2: the iteration counter stays inside its window while running
   assert_cnt_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q != '0) && (cnt_q <= CW'(STEPS)));
endmodule

// File: rtl/intdiv_mmio.sv
module intdiv_mmio
   import intdiv_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int STEP_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int STEPS = DATA_W / STEP_BITS;
   localparam int SCW   = $clog2(STEPS + 1);

   if (DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be at least 4");
   end
   if (STEP_BITS < 1 || (DATA_W % STEP_BITS) != 0) begin : g_bad_step
      $error("STEP_BITS must divide DATA_W");
   end

   logic [DATA_W-1:0] dvd_q, dsr_q, quo_q, rem_q;
   logic              ready_q, dirty_q;

   logic              wr_opnd, wr_quo, wr_rem, rd_quo;
   logic [DATA_W-1:0] dvd_next, dsr_next;
   logic              core_busy, core_done;
   logic [DATA_W-1:0] core_quo, core_rem;

   assign wr_opnd  = bus_wr && (bus_addr[2] == 1'b0);
   assign wr_quo   = bus_wr && (bus_addr == A_QUO);
   assign wr_rem   = bus_wr && (bus_addr == A_REM);
   assign rd_quo   = bus_rd && !bus_wr && (bus_addr == A_QUO);
   assign dvd_next = (wr_opnd && !bus_addr[0]) ? bus_wdata : dvd_q;
   assign dsr_next = (wr_opnd &&  bus_addr[0]) ? bus_wdata : dsr_q;

   intdiv_core #(.W(DATA_W), .K(STEP_BITS)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (wr_opnd),
      .signed_i(bus_addr[1]),
      .dvd_i   (dvd_next),
      .dsr_i   (dsr_next),
      .abort_i (wr_quo || wr_rem),
      .busy_o  (core_busy),
      .done_o  (core_done),
      .quo_o   (core_quo),
      .rem_o   (core_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvd_q   <= '0;
         dsr_q   <= '0;
         quo_q   <= '0;
         rem_q   <= '0;
         ready_q <= 1'b1;
         dirty_q <= 1'b0;
      end else if (wr_opnd) begin
         dvd_q   <= dvd_next;
         dsr_q   <= dsr_next;
         ready_q <= 1'b0;
         dirty_q <= 1'b1;
      end else if (wr_quo || wr_rem) begin
         if (wr_quo) quo_q <= bus_wdata;
         else        rem_q <= bus_wdata;
         ready_q <= 1'b1;
         dirty_q <= 1'b1;
      end else begin
         if (core_done) begin
            quo_q   <= core_quo;
            rem_q   <= core_rem;
            ready_q <= 1'b1;
         end
         if (rd_quo) dirty_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_UDVD, A_SDVD: bus_rdata = dvd_q;
         A_UDSR, A_SDSR: bus_rdata = dsr_q;
         A_QUO:          bus_rdata = quo_q;
         A_REM:          bus_rdata = rem_q;
         A_STAT: begin
            bus_rdata[STAT_READY] = ready_q;
            bus_rdata[STAT_DIRTY] = dirty_q;
         end
         default:        bus_rdata = '0;
      endcase
   end

   // Cycle counter used only by the latency assertion.
   logic [SCW-1:0] since_start;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          since_start <= '0;
      else if (wr_opnd)                    since_start <= '0;
      else if (since_start != SCW'(STEPS)) since_start <= since_start + 1'b1;
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_done |-> since_start == SCW'(STEPS - 1));
   assert_ready_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_busy |-> !ready_q);
   assert_start_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_opnd |=> dirty_q && !ready_q && core_busy);
   assert_qread_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_quo |=> !dirty_q);
   assert_rem_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rem |=> ready_q && dirty_q && !core_busy && rem_q == $past(bus_wdata));
   assert_quo_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_quo |=> ready_q && dirty_q && !core_busy && quo_q == $past(bus_wdata));
endmodule

// File: tb/intdiv_mmio_bench.sv
`timescale 1ns/1ps
module intdiv_mmio_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_b = 1'b0, rd_b = 1'b0, wr_s = 1'b0, rd_s = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata_b;
   logic [7:0]  rdata_s;
   int          n_chk = 0, n_fail = 0;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   intdiv_mmio u_intdiv_mmio (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_rd(rd_b),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b));

   intdiv_mmio #(.DATA_W(8), .STEP_BITS(2)) u_small (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr_s), .bus_rd(rd_s),
      .bus_addr(addr), .bus_wdata(wdata[7:0]), .bus_rdata(rdata_s));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic bw(input bit sm, input logic [2:0] a, input logic [31:0] d);
      addr = a; wdata = d;
      if (sm) wr_s = 1'b1; else wr_b = 1'b1;
      @(negedge clk);
      wr_s = 1'b0; wr_b = 1'b0;
   endtask

   task automatic br(input bit sm, input logic [2:0] a, output logic [31:0] d);
      addr = a;
      if (sm) rd_s = 1'b1; else rd_b = 1'b1;
      #1 d = sm ? {24'd0, rdata_s} : rdata_b;
      @(negedge clk);
      rd_s = 1'b0; rd_b = 1'b0;
   endtask

   function automatic logic [63:0] expv(input int w, input bit sgn,
                                        input logic [31:0] a, input logic [31:0] b);
      longint m, sa, sb, q, r;
      m  = (longint'(1) << w) - 1;
      sa = longint'(a) & m;
      sb = longint'(b) & m;
      if (sgn && sa[w-1]) sa = sa - (longint'(1) << w);
      if (sgn && sb[w-1]) sb = sb - (longint'(1) << w);
      if (sb == 0) begin
         q = sgn ? ((sa < 0) ? 1 : -1) : m;
         r = sa;
      end else begin
         q = sa / sb;
         r = sa % sb;
      end
      return {32'(q & m), 32'(r & m)};
   endfunction

   task automatic run(input bit sm, input bit sgn, input logic [31:0] a,
                      input logic [31:0] b, input string req);
      logic [31:0] q, r;
      logic [63:0] e;
      bw(sm, sgn ? 3'd2 : 3'd0, a);
      bw(sm, sgn ? 3'd3 : 3'd1, b);
      repeat (sm ? 4 : 8) @(negedge clk);
      br(sm, 3'd5, r);
      br(sm, 3'd4, q);
      e = expv(sm ? 8 : 32, sgn, a, b);
      chk(q == e[63:32], {req, " quotient"}, q, e[63:32]);
      chk(r == e[31:0], {req, " remainder"}, r, e[31:0]);
   endtask

   always @(posedge clk) begin
      static int cyc = 0;
      cyc++;
      if (cyc > 190000 && !finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] divs [12];
      divs = '{0, 1, 2, 3, 5, 7, 127, 128, 129, 200, 254, 255};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 reset state
      br(0, 3'd6, v); chk(v == 32'd1, "R3 R4 reset status", v, 32'd1);
      br(0, 3'd4, v); chk(v == 32'd0, "R3 reset quotient", v, 32'd0);

      // R2 latency and R3 ready low while running
      bw(0, 3'd0, 32'd1000);
      bw(0, 3'd1, 32'd7);
      for (int k = 0; k <= 8; k++) begin
         br(0, 3'd6, v);
         if (k == 0) chk(v == 32'd2, "R3 R4 status after start", v, 32'd2);
         if (k == 7) chk(v[0] == 1'b0, "R2 ready not early", v, 32'd2);
         if (k == 8) chk(v[0] == 1'b1, "R2 ready at latency", v, 32'd3);
      end

      // R5 remainder read keeps dirty, quotient read clears it
      br(0, 3'd5, v); chk(v == 32'd6, "R2 remainder", v, 32'd6);
      br(0, 3'd6, v); chk(v == 32'd3, "R5 dirty kept by remainder read", v, 32'd3);
      br(0, 3'd4, v); chk(v == 32'd142, "R2 quotient", v, 32'd142);
      br(0, 3'd6, v); chk(v == 32'd1, "R5 dirty cleared by quotient read", v, 32'd1);

      // R7 remainder write aborts a running calculation
      bw(0, 3'd0, 32'd100);
      bw(0, 3'd1, 32'd3);
      bw(0, 3'd5, 32'h55);
      repeat (12) @(negedge clk);
      br(0, 3'd5, v); chk(v == 32'h55, "R7 restored remainder", v, 32'h55);
      br(0, 3'd6, v); chk(v == 32'd3, "R7 ready and dirty", v, 32'd3);
      br(0, 3'd4, v); chk(v == 32'd142, "R7 quotient untouched by aborted run", v, 32'd142);

      // R8 quotient write mid-calculation
      bw(0, 3'd2, 32'hFFFF_FF00);
      bw(0, 3'd4, 32'h1234);
      br(0, 3'd6, v); chk(v == 32'd3, "R8 ready and dirty", v, 32'd3);
      repeat (10) @(negedge clk);
      br(0, 3'd4, v); chk(v == 32'h1234, "R8 loaded quotient", v, 32'h1234);

      // R6 operand read-back at both aliases
      bw(0, 3'd2, 32'hDEAD_BEEF);
      bw(0, 3'd1, 32'h0000_0011);
      br(0, 3'd0, v); chk(v == 32'hDEAD_BEEF, "R6 dividend unsigned alias", v, 32'hDEAD_BEEF);
      br(0, 3'd2, v); chk(v == 32'hDEAD_BEEF, "R6 dividend signed alias", v, 32'hDEAD_BEEF);
      br(0, 3'd3, v); chk(v == 32'h11, "R6 divisor signed alias", v, 32'h11);

      // R11 status upper bits and status writes
      repeat (10) @(negedge clk);
      br(0, 3'd6, v); chk(v == 32'd3, "R11 status upper bits zero", v, 32'd3);
      bw(0, 3'd6, 32'hFFFF_FFFC);
      br(0, 3'd6, v); chk(v == 32'd3, "R11 status write ignored", v, 32'd3);

      // R1 mode selected by alias, R9 signed, R10 zero divisor
      run(0, 0, 32'hFFFF_FFF0, 32'd4, "R1 unsigned alias");
      run(0, 1, 32'hFFFF_FFF0, 32'd4, "R1 signed alias");
      run(0, 1, -32'sd7, 32'd2, "R9");
      run(0, 1, 32'd7, -32'sd2, "R9");
      run(0, 1, -32'sd7, -32'sd2, "R9");
      run(0, 1, 32'h8000_0000, 32'hFFFF_FFFF, "R9 min by minus one");
      run(0, 0, 32'hFFFF_FFFF, 32'd1, "R1 full-scale unsigned");
      run(0, 0, 32'd123, 32'd0, "R10 unsigned");
      run(0, 1, -32'sd5, 32'd0, "R10 signed negative");
      run(0, 1, 32'd5, 32'd0, "R10 signed positive");

      // Near-exhaustive sweep of the 8-bit instance
      for (int sg = 0; sg < 2; sg++)
         for (int a = 0; a < 256; a++)
            for (int j = 0; j < 12; j++)
               run(1, sg[0], 32'(a), divs[j], sg ? "R9 R10 sweep" : "R1 R10 sweep");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule